// File: doc/BRIEF.md
# Commutation-Gated Output Control Shadow Register

This block keeps the per-channel output control settings of a PWM timer in two registers. Each channel has a main enable, a complementary enable and a 3-bit output mode. The bus side writes the preload register. The active register drives the output stage.

With preloading off, a write lands in both registers at once. With preloading on, a write waits in the preload register. It is copied to the active register only when a commutation event occurs. The event always comes from a software strobe. When the trigger-source select is set, a rising edge on the trigger input also creates an event.

Every event, whether or not it moves any data, is reported on a one-cycle flag. A controller can therefore stage the next commutation pattern for all channels ahead of time. The whole pattern is then switched in a single clock edge.

Top module: `outctl_shadow`

## Requirements
- R1: While reset is asserted, and after it is released, `pre_ctl`, `act_ctl` and `com_flag` are all zero until the first write or event.
- R2: Each channel uses 5 bits at offset `ch*5` in `wr_data`, `pre_ctl` and `act_ctl`. Bit 0 is the main enable, bit 1 is the complementary enable and bits 4:2 are the output mode.
- R3: With `preload_en` low, a write appears on both `pre_ctl` and `act_ctl` one cycle after the clock edge that samples `wr_en`.
- R4: With `preload_en` high, a write updates `pre_ctl` only. `act_ctl` keeps its value while no event occurs.
- R5: An event occurs in a cycle where `com_sw` is high. It also occurs when `trig_edge_en` is high and `trig_in` is high after being low at the previous clock edge. With `preload_en` high, an event copies the preload image into `act_ctl`.
- R6: With `trig_edge_en` low, edges on `trig_in` create no event: no flag and no transfer.
- R7: One rising edge of `trig_in` creates exactly one event. Holding `trig_in` high creates no further events.
- R8: When a write and an event fall in the same cycle with `preload_en` high, `act_ctl` takes the newly written value.
- R9: An event with `preload_en` low leaves `act_ctl` unchanged and still pulses `com_flag`.
- R10: `com_flag` is high for exactly one cycle. It rises together with the `act_ctl` update of the event that caused it.
- R11: Clearing `preload_en` while a value is pending does not copy that value to `act_ctl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control image |
| wr_data | input | NUM_CH*5 | Control image to write |
| preload_en | input | 1 | 1: writes wait for an event; 0: writes act at once |
| trig_edge_en | input | 1 | 1: trigger rising edges also create events |
| com_sw | input | 1 | Software commutation strobe, one cycle |
| trig_in | input | 1 | Synchronous trigger input |
| pre_ctl | output | NUM_CH*5 | Preload register contents |
| act_ctl | output | NUM_CH*5 | Active control image to the output stage |
| com_flag | output | 1 | One-cycle pulse per commutation event |

## Verification
The hardest situation to reach is a pending preload value being abandoned. This requires three steps in order: a write with preloading on, then preloading switched off, then an event that must not move the pending value. The stimulus table builds this sequence step by step and checks both register images after each step.

The trigger edge detector depends on the level seen at the previous edge. For this reason the table tracks the trigger level from row to row. A held-high level follows an accepted edge, and edges are also applied while the edge source is deselected.

// File: rtl/outctl_pkg.sv
`timescale 1ns/1ps
package outctl_pkg;
    localparam int MODE_W = 3;
    localparam int CTL_W  = MODE_W + 2;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              comp_en;
        logic              main_en;
    } chan_ctl_t;
endpackage

// File: rtl/outctl_com_detect.sv
`timescale 1ns/1ps
module outctl_com_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic com_sw,
    input  logic trig_in,
    input  logic trig_edge_en,
    output logic com_evt,
    output logic com_flag
);
    typedef struct packed {
        logic trig_prev;
        logic flag;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    trig_rise;

    always_comb begin
        st_d           = st_q;
        trig_rise      = trig_in & ~st_q.trig_prev;
        com_evt        = com_sw | (trig_edge_en & trig_rise);
        st_d.trig_prev = trig_in;
        st_d.flag      = com_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign com_flag = st_q.flag;

    // R6: the edge source is deselected and no strobe is given, so no flag follows
    p_sw_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_edge_en && !com_sw) |=> !com_flag);

    // R7: a level held high is not a new edge
    p_held_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!com_sw && trig_in && st_q.trig_prev) |=> !com_flag);

    // R10: the flag lasts one cycle unless a new event arrives
    p_flag_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (com_flag && !com_sw && !trig_edge_en) |=> !com_flag);
endmodule

// File: rtl/outctl_ctl_slice.sv
`timescale 1ns/1ps
module outctl_ctl_slice
    import outctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  chan_ctl_t wr_val,
    input  logic      preload_en,
    input  logic      com_evt,
    output chan_ctl_t pre_ctl,
    output chan_ctl_t act_ctl
);
    typedef struct packed {
        chan_ctl_t pre;
        chan_ctl_t act;
    } slice_st_t;

    slice_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.pre = wr_val;
        if (!preload_en) begin
            if (wr_en) st_d.act = wr_val;
        end else if (com_evt) begin
            st_d.act = st_d.pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pre_ctl = st_q.pre;
    assign act_ctl = st_q.act;

    // R3: a direct write reaches the active copy on the next cycle
    p_direct_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && wr_en) |=> (act_ctl == $past(wr_val)));

    // R4: with preloading on and no event, the active copy holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && !com_evt) |=> $stable(act_ctl));

    // R5: an event copies the pending preload value
    p_transfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && com_evt && !wr_en) |=> (act_ctl == $past(pre_ctl)));

    // R8: a write in the event cycle is the value transferred
    p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_en && com_evt && wr_en) |=> (act_ctl == $past(wr_val)));

    // R9 and R11: with preloading off, only a write moves the active copy
    p_no_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!preload_en && !wr_en) |=> $stable(act_ctl));
endmodule

// File: rtl/outctl_shadow.sv
`timescale 1ns/1ps
module outctl_shadow
    import outctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int IMG_W = NUM_CH * CTL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IMG_W-1:0] wr_data,
    input  logic             preload_en,
    input  logic             trig_edge_en,
    input  logic             com_sw,
    input  logic             trig_in,
    output logic [IMG_W-1:0] pre_ctl,
    output logic [IMG_W-1:0] act_ctl,
    output logic             com_flag
);
    logic com_evt;

    outctl_com_detect u_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .com_sw       (com_sw),
        .trig_in      (trig_in),
        .trig_edge_en (trig_edge_en),
        .com_evt      (com_evt),
        .com_flag     (com_flag)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        chan_ctl_t wr_val, pre_val, act_val;
        assign wr_val = chan_ctl_t'(wr_data[ch*CTL_W +: CTL_W]);

        outctl_ctl_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en),
            .wr_val     (wr_val),
            .preload_en (preload_en),
            .com_evt    (com_evt),
            .pre_ctl    (pre_val),
            .act_ctl    (act_val)
        );

        assign pre_ctl[ch*CTL_W +: CTL_W] = pre_val;
        assign act_ctl[ch*CTL_W +: CTL_W] = act_val;
    end

    // R1: the first cycle after reset shows an all-disabled image
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (act_ctl == '0 && pre_ctl == '0 && !com_flag));
endmodule

// File: tb/outctl_shadow_bench.sv
`timescale 1ns/1ps
module outctl_shadow_bench;
    localparam int W = 20;

    typedef struct packed {
        logic         wr;
        logic [W-1:0] data;
        logic         pl;
        logic         ts;
        logic         sw;
        logic         tr;
        logic [W-1:0] exp_act;
        logic [W-1:0] exp_pre;
        logic         exp_flag;
    } vec_t;

    localparam logic [W-1:0] D1 = 20'hABCDE, D2 = 20'h13579, D3 = 20'h2468A,
                             D4 = 20'hFFFFF, D5 = 20'h0F0F0;
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, D1, 1'b0, 1'b0, 1'b0, 1'b0, D1, D1, 1'b0}, // R3
        '{1'b1, D2, 1'b1, 1'b0, 1'b0, 1'b0, D1, D2, 1'b0}, // R4
        '{1'b0, D4, 1'b1, 1'b0, 1'b0, 1'b0, D1, D2, 1'b0}, // R4
        '{1'b0, D4, 1'b1, 1'b0, 1'b1, 1'b0, D2, D2, 1'b1}, // R5 strobe
        '{1'b1, D3, 1'b1, 1'b0, 1'b0, 1'b0, D2, D3, 1'b0}, // R10
        '{1'b0, D4, 1'b1, 1'b0, 1'b0, 1'b1, D2, D3, 1'b0}, // R6
        '{1'b0, D4, 1'b1, 1'b1, 1'b0, 1'b0, D2, D3, 1'b0}, // R6
        '{1'b0, D4, 1'b1, 1'b1, 1'b0, 1'b1, D3, D3, 1'b1}, // R5 edge
        '{1'b1, D4, 1'b1, 1'b1, 1'b0, 1'b1, D3, D4, 1'b0}, // R7
        '{1'b0, D1, 1'b1, 1'b1, 1'b0, 1'b1, D3, D4, 1'b0}, // R7
        '{1'b1, D5, 1'b1, 1'b1, 1'b1, 1'b0, D5, D5, 1'b1}, // R8
        '{1'b1, D2, 1'b1, 1'b0, 1'b0, 1'b0, D5, D2, 1'b0}, // R11
        '{1'b0, D1, 1'b0, 1'b0, 1'b0, 1'b0, D5, D2, 1'b0}, // R11
        '{1'b0, D1, 1'b0, 1'b0, 1'b1, 1'b0, D5, D2, 1'b1}, // R9 strobe
        '{1'b0, D1, 1'b0, 1'b1, 1'b0, 1'b1, D5, D2, 1'b1}, // R9 edge
        '{1'b1, D4, 1'b0, 1'b1, 1'b0, 1'b1, D4, D4, 1'b0}  // R3
    };
    localparam string TAGS [NV] = '{"R3", "R4", "R4", "R5", "R10", "R6", "R6", "R5",
                                    "R7", "R7", "R8", "R11", "R11", "R9", "R9", "R3"};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         preload_en = 1'b0;
    logic         trig_edge_en = 1'b0;
    logic         com_sw = 1'b0;
    logic         trig_in = 1'b0;
    logic [W-1:0] pre_ctl, act_ctl;
    logic         com_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    outctl_shadow #(.NUM_CH(4)) u_outctl_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .preload_en   (preload_en),
        .trig_edge_en (trig_edge_en),
        .com_sw       (com_sw),
        .trig_in      (trig_in),
        .pre_ctl      (pre_ctl),
        .act_ctl      (act_ctl),
        .com_flag     (com_flag)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] actual, input logic [W-1:0] expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, actual, expected);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; com_sw = 1'b0; wr_data = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "act_ctl in reset", act_ctl, '0);
        check("R1", "pre_ctl in reset", pre_ctl, '0);
        check("R1", "com_flag in reset", {19'b0, com_flag}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "act_ctl after release", act_ctl, '0);

        for (int i = 0; i < NV; i++) begin
            wr_en = VECS[i].wr; wr_data = VECS[i].data; preload_en = VECS[i].pl;
            trig_edge_en = VECS[i].ts; com_sw = VECS[i].sw; trig_in = VECS[i].tr;
            @(negedge clk);
            check(TAGS[i], $sformatf("act_ctl row %0d", i), act_ctl, VECS[i].exp_act);
            check(TAGS[i], $sformatf("pre_ctl row %0d", i), pre_ctl, VECS[i].exp_pre);
            check(TAGS[i], $sformatf("com_flag row %0d", i), {19'b0, com_flag},
                  {19'b0, VECS[i].exp_flag});
        end

        // R10: with inputs quiet the flag stays low after the last pulse
        idle_inputs(); trig_edge_en = 1'b0; trig_in = 1'b0;
        @(negedge clk);
        check("R10", "com_flag quiet", {19'b0, com_flag}, '0);

        // R2: field positions, with preloading off
        preload_en = 1'b0; wr_en = 1'b1; wr_data = 20'h00400;
        @(negedge clk);
        check("R2", "ch2 main enable at bit 10", {19'b0, act_ctl[10]}, 20'h1);
        check("R2", "only bit 10 set", act_ctl, 20'h00400);
        wr_data = 20'd5 << 7;
        @(negedge clk);
        check("R2", "ch1 mode at bits 9:7", {17'b0, act_ctl[9:7]}, 20'h5);
        wr_data = 20'h00002;
        @(negedge clk);
        check("R2", "ch0 complementary enable at bit 1", act_ctl, 20'h00002);
        idle_inputs();

        // R1: reset in the middle of operation clears both copies
        preload_en = 1'b1; wr_en = 1'b1; wr_data = D3;
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "act_ctl after mid-run reset", act_ctl, '0);
        check("R1", "pre_ctl after mid-run reset", pre_ctl, '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule